// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write port of a byte-wide flash device model. It treats each bus write (address plus data byte) as one step of a multi-write command. Every command starts with two key writes to fixed addresses. A following opcode then selects one of these actions: program a byte, erase one sector, erase the whole array, show the identifier codes, or return to plain reading. The block has no reset command. Any write that breaks the expected order drops the decoder back to plain reading.

The block holds a behavioural byte array that is split into equal sectors. A program write can only clear bits. An erase sets a whole sector, or the whole array, back to FFh. Each program or erase starts an internal busy period whose length in clock cycles is set by a parameter. While that period runs, writes are ignored. The read port is combinational. It returns array data, or the identifier codes while the identifier mode is active. The array size comes from `SECT_W` and `OFFS_W`, so simulation can use a small array. Magic addresses are compared on the low 16 bits of `wr_addr`.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, every read returns FFh, `busy` is low and the decoder is in plain read mode.
- R2: Every command starts with a write of AAh to address 5555h and then a write of 55h to address 2AAAh. Only `wr_addr[15:0]` is compared, so higher address bits do not matter.
- R3: After the two key writes, a write of A0h to 5555h arms a program. The next accepted write, at any address, replaces the addressed byte with the old value ANDed with the written data. `busy` is then high for exactly `PROG_CYC` cycles, starting in the cycle after that write.
- R4: After the key pair, the following writes start a sector erase: 80h to 5555h, AAh to 5555h, 55h to 2AAAh, then 30h to any address. The sector is `wr_addr[SECT_W+OFFS_W-1:OFFS_W]`, and the byte offset is the `OFFS_W` bits below it. Every byte of that sector becomes FFh and other sectors are untouched. `busy` is high for `SECT_CYC` cycles.
- R5: The same six-write order with a last write of 10h to 5555h erases the whole array to FFh. `busy` is high for `CERS_CYC` cycles.
- R6: After the key pair, a write of 90h to 5555h enters identifier mode. In that mode a read with `rd_addr[0]`=0 returns 40h, and a read with `rd_addr[0]`=1 returns 82h. The mode lasts until the next accepted write.
- R7: A single write of F0h, or F0h given as the third write after the key pair, leaves the decoder in plain read mode without changing the array.
- R8: Any write that does not match the expected next step returns the decoder to plain read mode. Examples are a wrong address, or FFh where an opcode is expected. The aborted command changes nothing.
- R9: Writes that arrive while `busy` is high are ignored. They change neither the array nor the command progress.
- R10: An array change is visible on `rd_data` in the cycle after the accepted write that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; refills the array with FFh |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data / command byte |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Array byte or identifier code |
| busy | output | 1 | High while a program or erase is timed |

## Verification
The bench first targets the abort paths. These are a wrong key address, an FFh opcode, an F0h opcode, and key addresses with high bits set. A decoder that advanced on a partial match would program a byte that must stay FFh. A decoder that compared all address bits would miss a valid program. Program attempts are issued during a sector erase. A design that accepted them while busy would clear a byte in a neighbouring sector, or leave the sequencer mid-command. The test also checks identifier reads on odd and even addresses and exits them with a single F0h. It counts the exact busy length for each operation, which exposes off-by-one timer loads. It checks that a second program ANDs with the first value instead of overwriting it.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [2:0] {
      ST_READ,
      ST_KEY1,
      ST_KEY2,
      ST_PGM_ARM,
      ST_ERS_A,
      ST_ERS_B,
      ST_ERS_C
   } cmd_state_t;

   localparam logic [15:0] ADDR_KEY_A = 16'h5555;
   localparam logic [15:0] ADDR_KEY_B = 16'h2AAA;

   localparam logic [7:0] KEY_A_DATA  = 8'hAA;
   localparam logic [7:0] KEY_B_DATA  = 8'h55;
   localparam logic [7:0] OPC_PGM     = 8'hA0;
   localparam logic [7:0] OPC_ERASE   = 8'h80;
   localparam logic [7:0] OPC_IDENT   = 8'h90;
   localparam logic [7:0] OPC_CHIP    = 8'h10;
   localparam logic [7:0] OPC_SECTOR  = 8'h30;

   localparam logic [7:0] IDENT_MFR   = 8'h40;
   localparam logic [7:0] IDENT_DEV   = 8'h82;

endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
   import flash_cmd_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        busy,
   input  logic [15:0] wr_a16,
   input  logic [7:0]  wr_data,
   output logic        pgm_go,
   output logic        sers_go,
   output logic        cers_go,
   output logic        id_mode
);

   cmd_state_t st, st_nx;
   logic       id_nx;
   logic       accept, at_a, at_b;

   assign accept = wr_en && !busy;
   assign at_a   = (wr_a16 == ADDR_KEY_A);
   assign at_b   = (wr_a16 == ADDR_KEY_B);

   always_comb begin
      st_nx   = st;
      id_nx   = id_mode;
      pgm_go  = 1'b0;
      sers_go = 1'b0;
      cers_go = 1'b0;
      if (accept) begin
         st_nx = ST_READ;
         id_nx = 1'b0;
         unique case (st)
            ST_READ:  if (at_a && wr_data == KEY_A_DATA) st_nx = ST_KEY1;
            ST_KEY1:  if (at_b && wr_data == KEY_B_DATA) st_nx = ST_KEY2;
            ST_KEY2: begin
               if (at_a) begin
                  if (wr_data == OPC_PGM)        st_nx = ST_PGM_ARM;
                  else if (wr_data == OPC_ERASE) st_nx = ST_ERS_A;
                  else if (wr_data == OPC_IDENT) id_nx = 1'b1;
               end
            end
            ST_PGM_ARM: pgm_go = 1'b1;
            ST_ERS_A: if (at_a && wr_data == KEY_A_DATA) st_nx = ST_ERS_B;
            ST_ERS_B: if (at_b && wr_data == KEY_B_DATA) st_nx = ST_ERS_C;
            ST_ERS_C: begin
               if (at_a && wr_data == OPC_CHIP) cers_go = 1'b1;
               else if (wr_data == OPC_SECTOR)  sers_go = 1'b1;
            end
            default: st_nx = ST_READ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_READ;
         id_mode <= 1'b0;
      end else begin
         st      <= st_nx;
         id_mode <= id_nx;
      end
   end

   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy) |=> ($stable(st) && $stable(id_mode)));

   // R6
   id_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(id_mode) |-> ($past(st) == ST_KEY2 && $past(wr_data) == OPC_IDENT));

   // R5
   go_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pgm_go, sers_go, cers_go}));

endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
   parameter int PROG_CYC = 6,
   parameter int SECT_CYC = 12,
   parameter int CERS_CYC = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pgm_go,
   input  logic sers_go,
   input  logic cers_go,
   output logic busy
);

   localparam int MAX_AB = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
   localparam int MAXC   = (MAX_AB > CERS_CYC) ? MAX_AB : CERS_CYC;
   localparam int CW     = (MAXC > 1) ? $clog2(MAXC) : 1;

   if (PROG_CYC < 1 || SECT_CYC < 1 || CERS_CYC < 1) begin : g_bad_dur
      $error("busy durations must be at least one cycle");
   end

   logic [CW-1:0] cnt;
   logic          busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt    <= '0;
      end else if (pgm_go) begin
         busy_q <= 1'b1;
         cnt    <= CW'(PROG_CYC - 1);
      end else if (sers_go) begin
         busy_q <= 1'b1;
         cnt    <= CW'(SECT_CYC - 1);
      end else if (cers_go) begin
         busy_q <= 1'b1;
         cnt    <= CW'(CERS_CYC - 1);
      end else if (busy_q) begin
         if (cnt == '0) busy_q <= 1'b0;
         else           cnt    <= cnt - 1'b1;
      end
   end

   assign busy = busy_q;

   // R9
   start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pgm_go || sers_go || cers_go) |-> !busy_q);

   // R3
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> ($past(cnt) == '0));

endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array #(
   parameter int SECT_W = 3,
   parameter int OFFS_W = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     pgm_go,
   input  logic                     sers_go,
   input  logic                     cers_go,
   input  logic [SECT_W+OFFS_W-1:0] wr_idx,
   input  logic [7:0]               wr_data,
   input  logic [SECT_W+OFFS_W-1:0] rd_idx,
   output logic [7:0]               rd_q
);

   localparam int N_SECT     = 1 << SECT_W;
   localparam int SECT_BYTES = 1 << OFFS_W;

   logic [SECT_W-1:0] wr_sect, rd_sect;
   logic [OFFS_W-1:0] wr_off, rd_off;
   logic [7:0]        sect_q [N_SECT];

   assign {wr_sect, wr_off} = wr_idx;
   assign {rd_sect, rd_off} = rd_idx;

   for (genvar g = 0; g < N_SECT; g++) begin : g_sect
      logic [7:0] cells [SECT_BYTES];
      logic       hit;
      assign hit = (wr_sect == SECT_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < SECT_BYTES; i++) cells[i] <= 8'hFF;
         end else if (cers_go || (sers_go && hit)) begin
            for (int i = 0; i < SECT_BYTES; i++) cells[i] <= 8'hFF;
         end else if (pgm_go && hit) begin
            cells[wr_off] <= cells[wr_off] & wr_data;
         end
      end

      assign sect_q[g] = cells[rd_off];
   end

   assign rd_q = sect_q[rd_sect];

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W   = 18,
   parameter int SECT_W   = 3,
   parameter int OFFS_W   = 4,
   parameter int PROG_CYC = 6,
   parameter int SECT_CYC = 12,
   parameter int CERS_CYC = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              busy
);

   localparam int IDX_W = SECT_W + OFFS_W;

   if (ADDR_W < 16 || ADDR_W < IDX_W || SECT_W < 1 || OFFS_W < 1) begin : g_bad_geom
      $error("address width too small for key addresses or array");
   end

   logic       pgm_go, sers_go, cers_go, id_mode;
   logic [7:0] arr_q;
   logic       unused_addr;

   assign unused_addr = ^{wr_addr, rd_addr};

   flash_cmd_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .busy    (busy),
      .wr_a16  (wr_addr[15:0]),
      .wr_data (wr_data),
      .pgm_go  (pgm_go),
      .sers_go (sers_go),
      .cers_go (cers_go),
      .id_mode (id_mode)
   );

   flash_busy_timer #(
      .PROG_CYC (PROG_CYC),
      .SECT_CYC (SECT_CYC),
      .CERS_CYC (CERS_CYC)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .pgm_go  (pgm_go),
      .sers_go (sers_go),
      .cers_go (cers_go),
      .busy    (busy)
   );

   flash_byte_array #(
      .SECT_W (SECT_W),
      .OFFS_W (OFFS_W)
   ) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .pgm_go  (pgm_go),
      .sers_go (sers_go),
      .cers_go (cers_go),
      .wr_idx  (wr_addr[IDX_W-1:0]),
      .wr_data (wr_data),
      .rd_idx  (rd_addr[IDX_W-1:0]),
      .rd_q    (arr_q)
   );

   assign rd_data = id_mode ? (rd_addr[0] ? IDENT_DEV : IDENT_MFR) : arr_q;

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> (!busy && !id_mode));

endmodule

// File: tb/sim_flash_cmd_decoder.sv
`timescale 1ns/1ps
module sim_flash_cmd_decoder;

   localparam int AW = 18, SW = 3, OW = 4;
   localparam int PC = 6, SC = 12, CC = 24;
   localparam int NB = 1 << (SW + OW);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0]    rd_data;
   logic          busy;

   always #2 clk = ~clk;

   flash_cmd_decoder #(
      .ADDR_W(AW), .SECT_W(SW), .OFFS_W(OW),
      .PROG_CYC(PC), .SECT_CYC(SC), .CERS_CYC(CC)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
   );

   int    checks = 0;
   int    errors = 0;
   string tag = "R1";
   bit    running = 0;
   bit    done = 0;

   // behavioural reference
   logic [7:0] m_mem [NB];
   int         m_st;
   bit         m_id;
   int         m_busy;

   task automatic m_step(input logic [AW-1:0] a, input logic [7:0] d);
      logic [15:0] a16;
      int idx, sec;
      a16 = a[15:0];
      idx = int'(a) % NB;
      sec = idx / (1 << OW);
      m_id = 0;
      case (m_st)
         0: m_st = (a16 == 16'h5555 && d == 8'hAA) ? 1 : 0;
         1: m_st = (a16 == 16'h2AAA && d == 8'h55) ? 2 : 0;
         2: begin
            m_st = 0;
            if (a16 == 16'h5555 && d == 8'hA0) m_st = 3;
            else if (a16 == 16'h5555 && d == 8'h80) m_st = 4;
            else if (a16 == 16'h5555 && d == 8'h90) m_id = 1;
         end
         3: begin m_mem[idx] = m_mem[idx] & d; m_busy = PC; m_st = 0; end
         4: m_st = (a16 == 16'h5555 && d == 8'hAA) ? 5 : 0;
         5: m_st = (a16 == 16'h2AAA && d == 8'h55) ? 6 : 0;
         6: begin
            m_st = 0;
            if (a16 == 16'h5555 && d == 8'h10) begin
               for (int i = 0; i < NB; i++) m_mem[i] = 8'hFF;
               m_busy = CC;
            end else if (d == 8'h30) begin
               for (int i = 0; i < (1 << OW); i++) m_mem[sec*(1<<OW)+i] = 8'hFF;
               m_busy = SC;
            end
         end
         default: m_st = 0;
      endcase
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NB; i++) m_mem[i] = 8'hFF;
         m_st = 0; m_id = 0; m_busy = 0;
      end else begin
         bit was_busy;
         was_busy = (m_busy > 0);
         if (m_busy > 0) m_busy--;
         if (wr_en && !was_busy) m_step(wr_addr, wr_data);
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (running && rst_n) begin
         logic [7:0] exp_rd;
         exp_rd = m_id ? (rd_addr[0] ? 8'h82 : 8'h40) : m_mem[int'(rd_addr) % NB];
         chk({tag, " rd_data"}, int'(rd_data), int'(exp_rd));
         chk({tag, " busy"}, int'(busy), (m_busy > 0) ? 1 : 0);
      end
   end

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input string req, input logic [7:0] exp);
      @(posedge clk); #1;
      rd_addr = a;
      @(negedge clk);
      chk(req, int'(rd_data), int'(exp));
   endtask

   task automatic keys();
      wr(18'h05555, 8'hAA);
      wr(18'h02AAA, 8'h55);
   endtask

   // counts negedges with busy high, starting just after the closing write
   task automatic busy_len(input string req, input int exp);
      int n = 0;
      @(negedge clk);
      while (busy && n < 1000) begin n++; @(negedge clk); end
      chk(req, n, exp);
   endtask

   task automatic report();
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         report();
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      running = 1;
      // R1 reset state
      tag = "R1";
      @(negedge clk);
      chk("R1 busy", int'(busy), 0);
      rd(18'h00000, "R1", 8'hFF);
      rd(18'h0007F, "R1", 8'hFF);

      // R3 program and R10 visibility
      tag = "R3";
      keys(); wr(18'h05555, 8'hA0); wr(18'h00012, 8'h3C);
      busy_len("R3 program busy length", PC);
      rd(18'h00012, "R10", 8'h3C);
      keys(); wr(18'h05555, 8'hA0); wr(18'h00012, 8'hF5);
      busy_len("R3 second busy length", PC);
      rd(18'h00012, "R3 AND", 8'h34);
      keys(); wr(18'h05555, 8'hA0); wr(18'h10023, 8'h0F);
      busy_len("R3 busy", PC);
      rd(18'h00023, "R3 high bits ignored", 8'h0F);

      // R2 key addresses with high bits set
      tag = "R2";
      wr(18'h35555, 8'hAA); wr(18'h12AAA, 8'h55);
      wr(18'h25555, 8'hA0); wr(18'h00040, 8'h55);
      busy_len("R2 busy", PC);
      rd(18'h00040, "R2", 8'h55);

      // R8 aborts
      tag = "R8";
      wr(18'h05554, 8'hAA); wr(18'h02AAA, 8'h55);
      wr(18'h05555, 8'hA0); wr(18'h00050, 8'h00);
      @(negedge clk); chk("R8 wrong key address busy", int'(busy), 0);
      rd(18'h00050, "R8 wrong key address", 8'hFF);
      keys(); wr(18'h05555, 8'hFF); wr(18'h00051, 8'h00);
      rd(18'h00051, "R8 FFh opcode", 8'hFF);

      // R7 F0 as third cycle
      tag = "R7";
      keys(); wr(18'h05555, 8'hF0); wr(18'h00052, 8'h00);
      rd(18'h00052, "R7 third-cycle F0", 8'hFF);

      // R6 identifier mode
      tag = "R6";
      keys(); wr(18'h05555, 8'h90);
      rd(18'h00000, "R6 manufacturer", 8'h40);
      rd(18'h00001, "R6 device", 8'h82);
      rd(18'h00012, "R6 even address", 8'h40);
      tag = "R7";
      wr(18'h05555, 8'hF0);
      rd(18'h00012, "R7 single F0 exits", 8'h34);

      // R4 sector erase with R9 program attempt while busy
      tag = "R4";
      keys(); wr(18'h05555, 8'h80); keys(); wr(18'h0001F, 8'h30);
      tag = "R9";
      keys(); wr(18'h05555, 8'hA0); wr(18'h00023, 8'h00);
      @(negedge clk);
      while (busy) @(negedge clk);
      rd(18'h00023, "R9 write during busy ignored", 8'h0F);
      tag = "R4";
      rd(18'h00012, "R4 erased byte", 8'hFF);
      rd(18'h00040, "R4 other sector kept", 8'h55);
      keys(); wr(18'h05555, 8'h80); keys(); wr(18'h00044, 8'h30);
      busy_len("R4 sector busy length", SC);
      rd(18'h00040, "R4 sector 4 erased", 8'hFF);
      rd(18'h00023, "R4 sector 2 kept", 8'h0F);

      // R5 chip erase
      tag = "R5";
      keys(); wr(18'h05555, 8'h80); keys(); wr(18'h05555, 8'h10);
      busy_len("R5 chip busy length", CC);
      for (int i = 0; i < NB; i += 7) rd(AW'(i), "R5 all erased", 8'hFF);
      rd(18'h00023, "R5 erased", 8'hFF);

      done = 1;
      running = 0;
      report();
   end

endmodule